// File: doc/BRIEF.md
# Decrementing-Compare Predicate Generator

This block builds a vector predicate mask from two scalar operands. Starting at the highest-numbered element and walking down to element 0, it compares a running copy of the first operand against the second operand. The running copy drops by one after every element. An element stays active only while every comparison so far has held. Once one comparison fails, that element and every lower element are inactive.

The comparison is signed. It can be done on the low 32 bits or on all 64 bits of each operand. The element size is chosen per operation. The unit handles one element per clock after a start strobe. When element 0 has been handled it pulses a done strobe. At the same moment it presents the mask and four condition flags, which summarise the first element, whether any element is set, and the last element.

A caller drives the operands and mode inputs together with a one-cycle start strobe. It then waits for done, and reads the mask and flags, which hold steady until the next accepted start.

Top module: `decpred_top`

## Requirements
- R1: The element size is 8 << sizeCode bits (codes 0..3 give 8, 16, 32, 64). The mask has one bit per byte of the vector. Element e reports its result at bit position e << sizeCode, and every other bit is 0.
- R2: When wideSel is 0, only bits [31:0] of each operand take part, compared as signed 32-bit values. When wideSel is 1, all 64 bits are compared as signed values.
- R3: The element count is (VEC_BITS/8) >> sizeCode. Element processing runs from the highest index down to 0, one element per clock. doneOut is high in the clock that follows exactly that many processing edges after the edge that accepts startIn.
- R4: The running condition starts true and is ANDed with each element's comparison. Once it is false, every lower element's bit is 0, even if a later comparison would hold.
- R5: After each element, the running operand is reduced by one, modulo 2^32 or 2^64 according to wideSel. The element size has no effect on this step, and the minimum signed value wraps to the maximum.
- R6: With geMode 0 the comparison is signed greater-than. With geMode 1 it is signed greater-or-equal.
- R7: At completion, flagN equals mask bit 0. flagZ is 1 when no mask bit is set. flagC is 1 when the highest element's bit is 0. flagV is always 0.
- R8: doneOut is high for exactly one cycle per accepted start.
- R9: While idle and with no start, predOut and the flags keep their values.
- R10: A startIn that arrives while an operation is running is ignored. The running operation's timing and result are unchanged.
- R11: After reset, predOut is 0, doneOut is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start strobe; accepted only when idle |
| opA | input | 64 | First operand, the decrementing value |
| opB | input | 64 | Second operand, the fixed threshold |
| wideSel | input | 1 | 0: 32-bit compare, 1: 64-bit compare |
| sizeCode | input | 2 | Element size code |
| geMode | input | 1 | 0: greater-than, 1: greater-or-equal |
| predOut | output | VEC_BITS/8 | Predicate mask, one bit per byte |
| flagN | output | 1 | Element 0 active |
| flagZ | output | 1 | No element active |
| flagC | output | 1 | Highest element inactive |
| flagV | output | 1 | Always 0 |
| doneOut | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its default 256-bit vector. This gives a 32-bit mask, and from 4 up to 32 elements per operation depending on the size code. That range puts every element-position spacing and both ends of the element-count range within reach, including the 32-cycle longest run. Operands are generated close to each other, so that the point where the running condition fails lands at varied element positions. Directed cases place the running operand at the signed minimum in both widths, where the wrap occurs. Other directed cases check equality under both compare modes, and a start issued while an operation is running.

// File: rtl/decpred_pkg.sv
package decpred_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } ctrl_strobe_t;
endpackage

// File: rtl/decpred_cmp.sv
module decpred_cmp (
  input  logic [63:0] lhs,
  input  logic [63:0] rhs,
  input  logic        wide,
  input  logic        orEqual,
  output logic        holds
);
  logic signed [63:0] lhsS;
  logic signed [63:0] rhsS;

  always_comb begin
    if (wide) begin
      lhsS = $signed(lhs);
      rhsS = $signed(rhs);
    end else begin
      lhsS = $signed({{32{lhs[31]}}, lhs[31:0]});
      rhsS = $signed({{32{rhs[31]}}, rhs[31:0]});
    end
    holds = (lhsS > rhsS) || (orEqual && (lhsS == rhsS));
  end
endmodule

// File: rtl/decpred_ctrl.sv
module decpred_ctrl
  import decpred_pkg::*;
#(
  parameter int PRED_BITS = 32,
  localparam int IDX_W = $clog2(PRED_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [1:0]       sizeCode,
  output ctrl_strobe_t     stb,
  output logic [IDX_W-1:0] elemIdx,
  output logic             running,
  output logic             doneOut
);
  logic [IDX_W-1:0] topIdx;

  assign topIdx = IDX_W'((PRED_BITS >> sizeCode) - 1);

  always_comb begin
    stb.load = startIn && !running;
    stb.step = running;
    stb.last = running && (elemIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      elemIdx <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= stb.last;
      if (stb.load) begin
        running <= 1'b1;
        elemIdx <= topIdx;
      end else if (running) begin
        if (elemIdx == '0) running <= 1'b0;
        else elemIdx <= elemIdx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/decpred_dp.sv
module decpred_dp
  import decpred_pkg::*;
#(
  parameter int PRED_BITS = 32,
  localparam int IDX_W = $clog2(PRED_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         stb,
  input  logic [IDX_W-1:0]     elemIdx,
  input  logic [63:0]          opA,
  input  logic [63:0]          opB,
  input  logic                 wideSel,
  input  logic [1:0]           sizeCode,
  input  logic                 geMode,
  output logic [PRED_BITS-1:0] maskReg,
  output logic                 flagN,
  output logic                 flagZ,
  output logic                 flagC
);
  logic [63:0]          runA;
  logic [63:0]          thrB;
  logic                 wideL;
  logic                 geL;
  logic [1:0]           sizeL;
  logic                 chain;
  logic                 cmpHolds;
  logic                 chainNext;
  logic [IDX_W-1:0]     bitPos;
  logic [IDX_W-1:0]     topPos;
  logic [PRED_BITS-1:0] maskNext;
  logic [63:0]          runDec;

  decpred_cmp u_cmp (
    .lhs    (runA),
    .rhs    (thrB),
    .wide   (wideL),
    .orEqual(geL),
    .holds  (cmpHolds)
  );

  always_comb begin
    chainNext = chain && cmpHolds;
    bitPos    = IDX_W'(elemIdx << sizeL);
    topPos    = IDX_W'(PRED_BITS - (1 << sizeL));
    maskNext  = maskReg;
    maskNext[bitPos] = chainNext;
    if (wideL) runDec = runA - 64'd1;
    else       runDec = {32'd0, runA[31:0] - 32'd1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runA    <= '0;
      thrB    <= '0;
      wideL   <= 1'b0;
      geL     <= 1'b0;
      sizeL   <= '0;
      chain   <= 1'b0;
      maskReg <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
      flagC   <= 1'b0;
    end else if (stb.load) begin
      runA    <= opA;
      thrB    <= opB;
      wideL   <= wideSel;
      geL     <= geMode;
      sizeL   <= sizeCode;
      chain   <= 1'b1;
      maskReg <= '0;
    end else if (stb.step) begin
      runA    <= runDec;
      chain   <= chainNext;
      maskReg <= maskNext;
      if (stb.last) begin
        flagN <= maskNext[0];
        flagZ <= ~|maskNext;
        flagC <= ~maskNext[topPos];
      end
    end
  end
endmodule

// File: rtl/decpred_top.sv
module decpred_top
  import decpred_pkg::*;
#(
  parameter int VEC_BITS = 256,
  localparam int PRED_BITS = VEC_BITS / 8,
  localparam int IDX_W = $clog2(PRED_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [63:0]          opA,
  input  logic [63:0]          opB,
  input  logic                 wideSel,
  input  logic [1:0]           sizeCode,
  input  logic                 geMode,
  output logic [PRED_BITS-1:0] predOut,
  output logic                 flagN,
  output logic                 flagZ,
  output logic                 flagC,
  output logic                 flagV,
  output logic                 doneOut
);
  ctrl_strobe_t     stb;
  logic [IDX_W-1:0] elemIdx;
  logic             running;

  decpred_ctrl #(.PRED_BITS(PRED_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .sizeCode(sizeCode),
    .stb     (stb),
    .elemIdx (elemIdx),
    .running (running),
    .doneOut (doneOut)
  );

  decpred_dp #(.PRED_BITS(PRED_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .elemIdx (elemIdx),
    .opA     (opA),
    .opB     (opB),
    .wideSel (wideSel),
    .sizeCode(sizeCode),
    .geMode  (geMode),
    .maskReg (predOut),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC)
  );

  assign flagV = 1'b0;
endmodule

// File: rtl/decpred_chk.sv
module decpred_chk #(
  parameter int PRED_BITS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 startIn,
  input logic                 running,
  input logic                 doneOut,
  input logic [PRED_BITS-1:0] predOut,
  input logic                 flagN,
  input logic                 flagZ,
  input logic                 flagC,
  input logic                 flagV
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startIn) |=> ($stable(predOut) && $stable(flagN) &&
                                $stable(flagZ) && $stable(flagC)));

  p_start_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(startIn));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (flagZ == (predOut == '0)));

  p_first_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (flagN == predOut[0]));

  p_v_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !flagV);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !running || $past(startIn));
endmodule

bind decpred_top decpred_chk #(.PRED_BITS(PRED_BITS)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .startIn(startIn),
  .running(running),
  .doneOut(doneOut),
  .predOut(predOut),
  .flagN  (flagN),
  .flagZ  (flagZ),
  .flagC  (flagC),
  .flagV  (flagV)
);

// File: tb/decpred_top_tb.sv
module decpred_top_tb;
  localparam int PB = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic [63:0]   opA = '0;
  logic [63:0]   opB = '0;
  logic          wideSel = 1'b0;
  logic [1:0]    sizeCode = '0;
  logic          geMode = 1'b0;
  logic [PB-1:0] predOut;
  logic          flagN, flagZ, flagC, flagV, doneOut;

  int nChecks = 0;
  int nFail = 0;
  int cycleCount = 0;

  always #2 clk = ~clk;

  decpred_top u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opA(opA), .opB(opB),
    .wideSel(wideSel), .sizeCode(sizeCode), .geMode(geMode),
    .predOut(predOut), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV), .doneOut(doneOut)
  );

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycleCount);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic void refModel(input logic [63:0] a, input logic [63:0] b,
                                   input logic wide, input logic [1:0] sz, input logic ge,
                                   output logic [PB-1:0] m, output logic n,
                                   output logic z, output logic c);
    logic [63:0] run = a;
    logic still = 1'b1;
    logic cond;
    int elems = PB >> sz;
    m = '0;
    for (int e = elems - 1; e >= 0; e--) begin
      if (wide) cond = ge ? ($signed(run) >= $signed(b)) : ($signed(run) > $signed(b));
      else cond = ge ? ($signed(run[31:0]) >= $signed(b[31:0]))
                     : ($signed(run[31:0]) > $signed(b[31:0]));
      still = still && cond;
      m[e << sz] = still;
      run = wide ? run - 64'd1 : {32'd0, run[31:0] - 32'd1};
    end
    n = m[0];
    z = (m == '0);
    c = ~m[PB - (1 << sz)];
  endfunction

  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input logic wide,
                      input logic [1:0] sz, input logic ge, input bit busyPoke);
    logic [PB-1:0] expM;
    logic expN, expZ, expC;
    int k = 0;
    logic [PB-1:0] heldM;
    refModel(a, b, wide, sz, ge, expM, expN, expZ, expC);
    @(negedge clk);
    opA = a; opB = b; wideSel = wide; sizeCode = sz; geMode = ge; startIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    while (k < 200) begin
      @(negedge clk);
      k++;
      if (doneOut) break;
      if (busyPoke && k == 2) begin
        startIn = 1'b1; opA = ~a; opB = ~b; sizeCode = sz + 2'd1; geMode = ~ge;
      end
      if (busyPoke && k == 3) startIn = 1'b0;
    end
    // R3: done after exactly element-count processing edges
    check(busyPoke ? "R10 done cycle under busy start" : "R3 done cycle", 64'(k), 64'(PB >> sz));
    check(busyPoke ? "R10 mask under busy start" : "R1 R4 R5 R6 mask", 64'(predOut), 64'(expM));
    check("R7 flagN", 64'(flagN), 64'(expN));
    check("R7 flagZ", 64'(flagZ), 64'(expZ));
    check("R7 flagC", 64'(flagC), 64'(expC));
    check("R7 flagV", 64'(flagV), 64'd0);
    heldM = predOut;
    opA = $urandom; opB = $urandom; sizeCode = 2'($urandom);
    @(negedge clk);
    check("R8 done one cycle", 64'(doneOut), 64'd0);
    @(negedge clk);
    check("R9 mask held", 64'(predOut), 64'(heldM));
    check("R9 flagZ held", 64'(flagZ), 64'(expZ));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset mask", 64'(predOut), 64'd0);
    check("R11 reset done", 64'(doneOut), 64'd0);
    check("R11 reset flags", 64'({flagN, flagZ, flagC, flagV}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5: 32-bit wrap, only top element set, sticky after wrap
    doOp(64'hDEAD_BEEF_8000_0001, 64'h0123_4567_8000_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    // R5: 64-bit wrap
    doOp(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b1, 2'd2, 1'b0, 1'b0);
    // R6: equality under greater-than then greater-or-equal
    doOp(64'd100, 64'd100, 1'b1, 2'd1, 1'b0, 1'b0);
    doOp(64'd100, 64'd100, 1'b1, 2'd1, 1'b1, 1'b0);
    // R2: low halves decide in narrow mode, upper halves differ
    doOp(64'h0000_0000_0000_0050, 64'hFFFF_FFFF_0000_0040, 1'b0, 2'd0, 1'b0, 1'b0);
    doOp(64'h0000_0000_0000_0050, 64'hFFFF_FFFF_0000_0040, 1'b1, 2'd0, 1'b0, 1'b0);
    // R1 all true across 64-bit elements
    doOp(64'd1000, 64'd0, 1'b1, 2'd3, 1'b1, 1'b0);
    // R10: start during busy
    doOp(64'd20, 64'd10, 1'b0, 2'd0, 1'b0, 1'b1);

    for (int i = 0; i < 60; i++) begin
      logic [63:0] b = {$urandom, $urandom};
      logic [63:0] a;
      if (i % 5 == 0) a = {$urandom, $urandom};
      else a = b + 64'($signed(32'($urandom % 40) - 32'sd5));
      doOp(a, b, 1'($urandom), 2'($urandom), 1'($urandom), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule